// File: doc/BRIEF.md
# Change-Triggered Interrupt Aggregator

This block collects eleven interrupt request lines and reports them upstream as one interrupt. The interrupt is a single posted write: a programmed data word sent to a programmed target address over a write-request port with a valid/ready handshake. A request is raised only when an enabled line changes level. A line that is already high when software unmasks it does not raise one. The live line levels can be read, so software can emulate level-triggered behaviour by polling the level register after it services the latched requests.

Software uses a small register port. It can write the enable mask and the target word. It can read a latched-request register and a change-pending register, both of which clear when read, and a live-level register that never changes on a read. Several line changes that arrive while an upstream write is stalled are merged, and only one further write follows. Register offsets on `reg_addr` are 0 mask, 1 latched requests, 2 pending changes, 3 live levels and 4 target. Any other offset reads as zero.

Top module: `irq_gather`

## Requirements
- R1: The live-level register (offset 3) returns the current level of each of the eleven lines on bits 10:0, whatever the mask, request and pending state. A new level appears there two clock edges after it reaches `irq_in`.
- R2: A change of level on line i while mask bit i is set sets bit i of the latched-request register (offset 1). Only bits in the implemented set 0x5FF are ever reported, so bit 9 always reads 0.
- R3: When a request bit is set and no upstream write is outstanding, `up_valid` rises on the next clock edge. One handshake completes the write.
- R4: Setting a mask bit while that line is already high produces no request bit and no upstream write. The next change of that line does produce both.
- R5: A read of the latched-request register returns its bits and clears them in the same access. A request that is raised in the same cycle as the read is kept for the next read.
- R6: The pending register (offset 2) records a change on any of the eleven lines, masked or not. Reading it returns and clears those bits and leaves the live-level register unchanged.
- R7: The target register (offset 4) holds the address and the data word combined. An upstream write carries `up_addr` = target with bits 4:0 cleared and `up_data` = target bits 4:0, zero-extended. Both stay stable while `up_valid` waits for `up_ready`.
- R8: Any number of enabled changes that occur while an upstream write is outstanding produce exactly one further write after that handshake.
- R9: After reset the mask, latched-request and pending registers read zero and `up_valid` is low.
- R10: Clearing a mask bit disables the line. Later changes on it set no request bit and issue no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 11 | Raw asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of `reg_rd` |
| up_valid | output | 1 | Upstream write request valid |
| up_ready | input | 1 | Upstream accepts the write |
| up_addr | output | 32 | Upstream write address |
| up_data | output | 32 | Upstream write data |

## Verification
A wrong previous-level flop shows up as spurious or missing request bits, and as extra or missing upstream writes, within three cycles of a line change. A lost merge flag in the launcher shows up as a missing second handshake right after a stalled write completes. A read-clear that is too wide or too narrow shows up on the very next read of the same register, for example when a request that arrived during a read is missing or when cleared bits come back.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
    typedef enum logic [2:0] {
        RA_MASK  = 3'd0,
        RA_REQ   = 3'd1,
        RA_PEND  = 3'd2,
        RA_LEVEL = 3'd3,
        RA_TGT   = 3'd4
    } reg_ofs_e;
endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign lvl_o = stg_q[STAGES-1];

    p_sync_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_o == $past(stg_q[STAGES-2]));
endmodule

// File: rtl/irqa_edge.sv
module irqa_edge #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] chg_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign chg_o = lvl_i ^ prev_q;
endmodule

// File: rtl/irqa_launch.sv
module irqa_launch #(
    parameter int AW = 32,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [AW-1:0] tgt_i,
    output logic          up_valid,
    input  logic          up_ready,
    output logic [AW-1:0] up_addr,
    output logic [AW-1:0] up_data
);
    typedef struct packed {
        logic          valid;
        logic          again;
        logic [AW-1:0] addr;
        logic [AW-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic load;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (!st_q.valid) begin
            if (trig_i) begin
                st_d.valid = 1'b1;
                load       = 1'b1;
            end
        end else if (up_ready) begin
            st_d.valid = st_q.again | trig_i;
            st_d.again = 1'b0;
            load       = st_d.valid;
        end else begin
            st_d.again = st_q.again | trig_i;
        end
        if (load) begin
            st_d.addr = {tgt_i[AW-1:DW], {DW{1'b0}}};
            st_d.data = {{(AW-DW){1'b0}}, tgt_i[DW-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_valid = st_q.valid;
    assign up_addr  = st_q.addr;
    assign up_data  = st_q.data;

    p_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !up_valid) |=> up_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ready) |=> (up_valid && $stable(up_addr) && $stable(up_data)));

    p_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_valid) |-> $past(trig_i));
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irqa_pkg::*;
#(
    parameter int          N_LINES = 11,
    parameter logic [10:0] IMPL    = 11'h5FF,
    parameter int          AW      = 32,
    parameter int          DW      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [2:0]         reg_addr,
    input  logic [AW-1:0]      reg_wdata,
    output logic [AW-1:0]      reg_rdata,
    output logic               up_valid,
    input  logic               up_ready,
    output logic [AW-1:0]      up_addr,
    output logic [AW-1:0]      up_data
);
    localparam logic [N_LINES-1:0] IMPL_M = N_LINES'(IMPL);

    typedef struct packed {
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] req;
        logic [N_LINES-1:0] pend;
        logic [AW-1:0]      tgt;
    } regs_t;

    regs_t r_d, r_q;
    logic [N_LINES-1:0] lvl, chg, ev;
    logic trig;

    irqa_sync #(.W(N_LINES), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(irq_in), .lvl_o(lvl));

    irqa_edge #(.W(N_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .chg_o(chg));

    assign ev   = chg & r_q.mask & IMPL_M;
    assign trig = |ev;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                RA_MASK: r_d.mask = reg_wdata[N_LINES-1:0];
                RA_TGT:  r_d.tgt  = reg_wdata;
                default: ;
            endcase
        end
        if (reg_rd && reg_addr == RA_REQ)  r_d.req  = '0;
        if (reg_rd && reg_addr == RA_PEND) r_d.pend = '0;
        r_d.req  = r_d.req | ev;
        r_d.pend = r_d.pend | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                RA_MASK:  reg_rdata[N_LINES-1:0] = r_q.mask;
                RA_REQ:   reg_rdata[N_LINES-1:0] = r_q.req;
                RA_PEND:  reg_rdata[N_LINES-1:0] = r_q.pend;
                RA_LEVEL: reg_rdata[N_LINES-1:0] = lvl;
                RA_TGT:   reg_rdata              = r_q.tgt;
                default:  reg_rdata              = '0;
            endcase
        end
    end

    irqa_launch #(.AW(AW), .DW(DW)) u_launch (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .tgt_i(r_q.tgt),
        .up_valid(up_valid), .up_ready(up_ready),
        .up_addr(up_addr), .up_data(up_data));

    p_unimpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_REQ) |-> ((reg_rdata[N_LINES-1:0] & ~IMPL_M) == '0));

    p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_REQ) |=> ((r_q.req & ~$past(ev)) == '0));

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg & r_q.mask) == '0) |=> ((r_q.req & ~$past(r_q.req)) == '0));
endmodule

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_in = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        up_valid, up_ready = 1'b1;
    logic [31:0] up_addr, up_data;

    int n_chk = 0, n_fail = 0, tx_cnt = 0;
    logic [31:0] exp_addr = '0, exp_data = '0;

    always #2.5 clk = ~clk;

    irq_gather u_irq_gather (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .up_valid(up_valid), .up_ready(up_ready),
        .up_addr(up_addr), .up_data(up_data));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_req(input logic [10:0] tog, input logic [10:0] m);
        return {21'd0, tog & m & 11'h5FF};
    endfunction

    always @(negedge clk) begin
        if (rst_n && up_valid && up_ready) begin
            tx_cnt++;
            check("R7 up_addr", up_addr, exp_addr);
            check("R7 up_data", up_data, exp_data);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_target(input logic [31:0] t);
        wreg(3'd4, t);
        exp_addr = {t[31:5], 5'd0};
        exp_data = {27'd0, t[4:0]};
    endtask

    initial begin
        logic [31:0] v, a0;
        logic [10:0] m, tog, nxt;
        int base;
        void'($urandom(32'd20250611));
        cyc(4);
        rst_n = 1'b1;
        cyc(2);

        check("R9 up_valid after reset", {31'd0, up_valid}, 32'd0);
        rreg(3'd0, v); check("R9 mask reset", v, 32'd0);
        rreg(3'd1, v); check("R9 req reset", v, 32'd0);
        rreg(3'd2, v); check("R9 pend reset", v, 32'd0);

        set_target(32'hABCD_1234);

        // R4: line already high when unmasked gives nothing
        irq_in[3] = 1'b1; cyc(6);
        rreg(3'd2, v); check("R6 pend masked change", v, 32'h008);
        rreg(3'd3, v); check("R6 level kept after pend read", v, 32'h008);
        base = tx_cnt;
        wreg(3'd0, 32'h008); cyc(6);
        rreg(3'd1, v); check("R4 no req on unmask", v, 32'd0);
        check("R4 no write on unmask", tx_cnt - base, 0);
        irq_in[3] = 1'b0; cyc(6);
        rreg(3'd1, v); check("R4 req on later change", v, 32'h008);
        check("R3 one write", tx_cnt - base, 1);

        // R2: bit 9 never reported
        wreg(3'd0, 32'h7FF); base = tx_cnt;
        irq_in[9] = 1'b1; cyc(6);
        rreg(3'd1, v); check("R2 bit9 suppressed", v, 32'd0);
        check("R2 bit9 no write", tx_cnt - base, 0);
        rreg(3'd3, v); check("R1 level bit9", v, 32'h200);
        irq_in[9] = 1'b0; cyc(6);
        rreg(3'd2, v);

        // R10: disabling a line
        wreg(3'd0, 32'h001); wreg(3'd0, 32'h000); base = tx_cnt;
        irq_in[0] = 1'b1; cyc(6);
        rreg(3'd1, v); check("R10 disabled no req", v, 32'd0);
        check("R10 disabled no write", tx_cnt - base, 0);
        irq_in[0] = 1'b0; cyc(6);
        rreg(3'd2, v);

        // R5: request arriving during a read is kept
        wreg(3'd0, 32'h7FF);
        irq_in[0] = 1'b1; cyc(6);
        irq_in[1] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rreg(3'd1, v); check("R5 read returns old", v, 32'h001);
        cyc(2);
        rreg(3'd1, v); check("R5 same-cycle request kept", v, 32'h002);
        rreg(3'd1, v); check("R5 cleared after read", v, 32'd0);
        irq_in = '0; cyc(6);
        rreg(3'd1, v); rreg(3'd2, v);

        // R8: merge while stalled
        up_ready = 1'b0; base = tx_cnt;
        irq_in[4] = 1'b1; cyc(5);
        check("R3 valid while stalled", {31'd0, up_valid}, 32'd1);
        a0 = up_addr;
        irq_in[5] = 1'b1; cyc(3);
        irq_in[6] = 1'b1; cyc(5);
        check("R7 addr stable while stalled", up_addr, a0);
        check("R8 no write while stalled", tx_cnt - base, 0);
        up_ready = 1'b1; cyc(6);
        check("R8 exactly one further write", tx_cnt - base, 2);
        check("R8 idle after merge", {31'd0, up_valid}, 32'd0);
        irq_in = '0; cyc(6);
        rreg(3'd1, v); rreg(3'd2, v);

        // Random patterns: R1 R2 R3 R6
        nxt = '0;
        for (int it = 0; it < 40; it++) begin
            m   = 11'($urandom);
            tog = 11'($urandom);
            if (it % 8 == 3) set_target($urandom);
            wreg(3'd0, {21'd0, m});
            base = tx_cnt;
            nxt = nxt ^ tog;
            irq_in = nxt;
            cyc(6);
            rreg(3'd1, v); check("R2 random req", v, exp_req(tog, m));
            rreg(3'd2, v); check("R6 random pend", v, {21'd0, tog});
            rreg(3'd3, v); check("R1 random level", v, {21'd0, nxt});
            check("R3 random write count", tx_cnt - base, (exp_req(tog, m) != 0) ? 1 : 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule